// File: doc/BRIEF.md
# Effective Address Calculation Unit

This unit turns a six-bit addressing field (three mode bits over three register bits) and an operand size into the effective address used by a 16/32-bit CISC core. Once a request is accepted, the unit reads the base address register through a single register-file read port. It collects any 16-bit extension words the mode needs, one per accepted handshake. It then publishes the address, an optional address-register write-back for the auto-stepping modes, the added bus-cycle count and three legality flags, all together with a one-cycle `done` pulse.

A request is given by pulsing `start` while the unit is idle, with the field, the size and the program counter. The program counter value is the address of the first extension word. Register-direct fields produce no address: they only report the register number on `reg_idx`. Fetching operands, memory access and opcode decoding sit outside this unit.

Top module: `ea_unit`

## Requirements
- R1: Field values 0x00-0x0F are register direct: `reg_idx` is the field's low four bits (0-7 data, 8-15 address registers), `ea` is 0, `cycles` is 0 and no extension word is taken. Field 0x10-0x17 gives `ea` equal to address register An, where n is field[2:0].
- R2: Field 0x18-0x1F (post-increment) gives `ea` equal to the old An and writes An+step back, with `an_we` high and `an_widx` equal to n. The step is 1, 2 or 4 for size codes 0 (byte), 1 (word) and 2 (long).
- R3: Field 0x20-0x27 (pre-decrement) subtracts the step first: both `ea` and `an_wdata` equal An-step. No other mode raises `an_we`.
- R4: A byte-size step on register 7 is 2 instead of 1, for both post-increment and pre-decrement.
- R5: Field 0x28-0x2F gives An plus the sign-extended first word. Field 0x38 gives the sign-extended first word. Field 0x39 gives {first word, second word}. Field 0x3C (immediate) gives {first, second} for long size and the first word zero-extended otherwise.
- R6: Indexed modes take an extension word whose bits 15:12 pick the index register (0-7 data, 8-15 address). Bit 11 selects the full 32-bit register (1) or its sign-extended low half (0). Bits 7:0 are a signed displacement. Field 0x30-0x37 gives An + index + displacement.
- R7: PC-relative modes use `pc_in` sign-extended from 24 bits as the base. Field 0x3A adds the sign-extended first word to it. Field 0x3B adds the R6 index and displacement to it.
- R8: `cycles` for byte/word versus long operands is: An-indirect and post-increment 4/8, pre-decrement 6/10, An+d16 8/12, An-indexed 10/14, absolute short 8/12, absolute long 12/16, PC+d16 8/12, PC-indexed 10/14, immediate 4/8.
- R9: `ok_read` is high for fields up to 0x3C. `ok_write` is high for fields up to 0x39. `ok_ctrl` is high only for 0x10-0x17 and 0x28-0x3B.
- R10: `ext_ready` is high only while words are still owed, and each word is taken on a cycle with `ext_valid` and `ext_ready` both high. `done` pulses for one cycle, two clock edges after the last word is taken, or after the start edge if no word is needed. Words needed: one for 0x28-0x38, 0x3A and 0x3B; two for 0x39; for 0x3C, two at long size and one otherwise. After reset `done`, `ext_ready` and `an_we` are low.
- R11: Field values above 0x3C clear all three legality flags, take no word, give `ea` and `cycles` of 0 and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (taken only when idle) |
| mode_in | input | 6 | Addressing field, mode bits over register bits |
| size_in | input | 2 | Operand size code: 0 byte, 1 word, 2 long |
| pc_in | input | 24 | Address of the first extension word |
| rf_idx | output | 4 | Register-file read index (0-7 data, 8-15 address) |
| rf_data | input | 32 | Register-file read data for `rf_idx`, same cycle |
| ext_valid | input | 1 | Extension word offered |
| ext_data | input | 16 | Extension word |
| ext_ready | output | 1 | Unit accepts an extension word |
| done | output | 1 | One-cycle result strobe |
| ea | output | 32 | Effective address or immediate value |
| reg_idx | output | 4 | Register number for register-direct fields |
| an_we | output | 1 | Address-register write-back enable |
| an_widx | output | 3 | Address register to write back |
| an_wdata | output | 32 | Write-back value |
| cycles | output | 5 | Extra bus cycles for the mode |
| ok_read | output | 1 | Field legal as a source |
| ok_write | output | 1 | Field legal as a destination |
| ok_ctrl | output | 1 | Field legal for address-only use |

## Verification
The assertions assume that `size_in` is never 3 and that `rf_data` answers the index on `rf_idx` within the same cycle. They also assume that `start` is only raised while no calculation is under way, since a start pulse given during a calculation is dropped. The bench models the register file as a combinational array. It waits for `done` before it issues the next request, and it sweeps all 64 field values at the three legal sizes and with both index widths, stalling `ext_valid` on some requests.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        MC_DREG, MC_AREG, MC_IND, MC_POST, MC_PRE, MC_D16, MC_IDX,
        MC_ABSW, MC_ABSL, MC_PCD16, MC_PCIDX, MC_IMM, MC_BAD
    } mode_e;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FIN} st_e;

    typedef struct packed {
        st_e         st;
        logic [5:0]  mode;
        logic [1:0]  size;
        logic [23:0] pc;
        logic [31:0] base;
        logic [15:0] w0;
        logic [15:0] w1;
        logic [1:0]  cnt;
        logic        done;
        logic [31:0] ea;
        logic [3:0]  ridx;
        logic        we;
        logic [2:0]  widx;
        logic [31:0] wdata;
        logic [4:0]  cyc;
        logic        rd;
        logic        wr;
        logic        ctl;
    } ea_state_t;

    function automatic mode_e ea_class(input logic [5:0] f);
        mode_e c;
        case (f[5:3])
            3'd0: c = MC_DREG;
            3'd1: c = MC_AREG;
            3'd2: c = MC_IND;
            3'd3: c = MC_POST;
            3'd4: c = MC_PRE;
            3'd5: c = MC_D16;
            3'd6: c = MC_IDX;
            default: begin
                case (f[2:0])
                    3'd0: c = MC_ABSW;
                    3'd1: c = MC_ABSL;
                    3'd2: c = MC_PCD16;
                    3'd3: c = MC_PCIDX;
                    3'd4: c = MC_IMM;
                    default: c = MC_BAD;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic [1:0] ea_words(input mode_e c, input logic big);
        logic [1:0] n;
        case (c)
            MC_D16, MC_IDX, MC_ABSW, MC_PCD16, MC_PCIDX: n = 2'd1;
            MC_ABSL: n = 2'd2;
            MC_IMM:  n = big ? 2'd2 : 2'd1;
            default: n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [5:0] field,
    input  logic [1:0] size,
    output mode_e      cls,
    output logic [4:0] cyc,
    output logic       rd_ok,
    output logic       wr_ok,
    output logic       ctl_ok,
    output logic [2:0] step
);
    logic big;
    assign big = size[1];

    always_comb begin
        cls = ea_class(field);
        case (cls)
            MC_IND, MC_POST:            cyc = big ? 5'd8  : 5'd4;
            MC_PRE:                     cyc = big ? 5'd10 : 5'd6;
            MC_D16, MC_ABSW, MC_PCD16:  cyc = big ? 5'd12 : 5'd8;
            MC_IDX, MC_PCIDX:           cyc = big ? 5'd14 : 5'd10;
            MC_ABSL:                    cyc = big ? 5'd16 : 5'd12;
            MC_IMM:                     cyc = big ? 5'd8  : 5'd4;
            default:                    cyc = 5'd0;
        endcase
        rd_ok  = (cls != MC_BAD);
        wr_ok  = rd_ok && (cls != MC_PCD16) && (cls != MC_PCIDX) && (cls != MC_IMM);
        ctl_ok = (cls == MC_IND) || (cls == MC_D16) || (cls == MC_IDX) ||
                 (cls == MC_ABSW) || (cls == MC_ABSL) || (cls == MC_PCD16) ||
                 (cls == MC_PCIDX);
        if (size == 2'd0)
            step = (field[2:0] == 3'd7) ? 3'd2 : 3'd1;
        else if (size == 2'd1)
            step = 3'd2;
        else
            step = 3'd4;
    end
endmodule

// File: rtl/ea_index_offset.sv
module ea_index_offset #(
    parameter int DW = 32,
    parameter int XW = 16,
    parameter int SW = 8
) (
    input  logic          long_sel,
    input  logic [SW-1:0] disp,
    input  logic [DW-1:0] xreg,
    output logic [DW-1:0] offset
);
    logic [DW-1:0] xval;
    logic [DW-1:0] dext;

    always_comb begin
        xval   = long_sel ? xreg : {{(DW-XW){xreg[XW-1]}}, xreg[XW-1:0]};
        dext   = {{(DW-SW){disp[SW-1]}}, disp};
        offset = xval + dext;
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [5:0]  mode_in,
    input  logic [1:0]  size_in,
    input  logic [23:0] pc_in,
    output logic [3:0]  rf_idx,
    input  logic [31:0] rf_data,
    input  logic        ext_valid,
    input  logic [15:0] ext_data,
    output logic        ext_ready,
    output logic        done,
    output logic [31:0] ea,
    output logic [3:0]  reg_idx,
    output logic        an_we,
    output logic [2:0]  an_widx,
    output logic [31:0] an_wdata,
    output logic [4:0]  cycles,
    output logic        ok_read,
    output logic        ok_write,
    output logic        ok_ctrl
);
    ea_state_t r_d, r_q;

    mode_e      cls_cur;
    logic [4:0] cyc_cur;
    logic       rd_cur, wr_cur, ctl_cur;
    logic [2:0] step_cur;
    logic [31:0] idx_off;
    logic [1:0] need_new, need_cur;
    logic [31:0] pc_sx, d16_sx, step_ext;

    ea_mode_decode dec_i (
        .field(r_q.mode), .size(r_q.size), .cls(cls_cur), .cyc(cyc_cur),
        .rd_ok(rd_cur), .wr_ok(wr_cur), .ctl_ok(ctl_cur), .step(step_cur)
    );

    ea_index_offset #(.DW(32), .XW(16), .SW(8)) idx_i (
        .long_sel(r_q.w0[11]), .disp(r_q.w0[7:0]), .xreg(rf_data), .offset(idx_off)
    );

    assign need_new  = ea_words(ea_class(mode_in), size_in[1]);
    assign need_cur  = ea_words(cls_cur, r_q.size[1]);
    assign pc_sx     = {{8{r_q.pc[23]}}, r_q.pc};
    assign d16_sx    = {{16{r_q.w0[15]}}, r_q.w0};
    assign step_ext  = {29'd0, step_cur};
    assign ext_ready = (r_q.st == ST_WAIT);
    assign rf_idx    = (r_q.st == ST_IDLE) ? {1'b1, mode_in[2:0]} : r_q.w0[15:12];

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.we   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.mode = mode_in;
                    r_d.size = size_in;
                    r_d.pc   = pc_in;
                    r_d.base = rf_data;
                    r_d.cnt  = 2'd0;
                    r_d.st   = (need_new == 2'd0) ? ST_FIN : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ext_valid) begin
                    if (r_q.cnt == 2'd0) r_d.w0 = ext_data;
                    else                 r_d.w1 = ext_data;
                    r_d.cnt = r_q.cnt + 2'd1;
                    if (r_q.cnt + 2'd1 == need_cur) r_d.st = ST_FIN;
                end
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.cyc   = cyc_cur;
                r_d.rd    = rd_cur;
                r_d.wr    = wr_cur;
                r_d.ctl   = ctl_cur;
                r_d.widx  = r_q.mode[2:0];
                r_d.ridx  = 4'd0;
                r_d.wdata = r_q.base;
                case (cls_cur)
                    MC_DREG, MC_AREG: begin
                        r_d.ea   = 32'd0;
                        r_d.ridx = r_q.mode[3:0];
                    end
                    MC_IND:  r_d.ea = r_q.base;
                    MC_POST: begin
                        r_d.ea    = r_q.base;
                        r_d.we    = 1'b1;
                        r_d.wdata = r_q.base + step_ext;
                    end
                    MC_PRE: begin
                        r_d.ea    = r_q.base - step_ext;
                        r_d.we    = 1'b1;
                        r_d.wdata = r_q.base - step_ext;
                    end
                    MC_D16:   r_d.ea = r_q.base + d16_sx;
                    MC_IDX:   r_d.ea = r_q.base + idx_off;
                    MC_ABSW:  r_d.ea = d16_sx;
                    MC_ABSL:  r_d.ea = {r_q.w0, r_q.w1};
                    MC_PCD16: r_d.ea = pc_sx + d16_sx;
                    MC_PCIDX: r_d.ea = pc_sx + idx_off;
                    MC_IMM:   r_d.ea = r_q.size[1] ? {r_q.w0, r_q.w1} : {16'd0, r_q.w0};
                    default:  r_d.ea = 32'd0;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = r_q.done;
    assign ea       = r_q.ea;
    assign reg_idx  = r_q.ridx;
    assign an_we    = r_q.we;
    assign an_widx  = r_q.widx;
    assign an_wdata = r_q.wdata;
    assign cycles   = r_q.cyc;
    assign ok_read  = r_q.rd;
    assign ok_write = r_q.wr;
    assign ok_ctrl  = r_q.ctl;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ext_ready,
    input logic        done,
    input logic [31:0] ea,
    input logic        an_we,
    input logic [31:0] an_wdata,
    input logic [4:0]  cycles,
    input logic        ok_read,
    input logic        ok_write,
    input logic        ok_ctrl
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ready |-> !done); // R10
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        an_we |-> done); // R3
    AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok_write) |-> ok_read); // R9
    AST_CTRL_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok_ctrl) |-> !an_we); // R9
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok_read) |-> (cycles == 5'd0 && ea == 32'd0 && !an_we)); // R11
    AST_PRE_WB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && an_we && cycles inside {5'd6, 5'd10}) |-> (an_wdata == ea)); // R3
endmodule

bind ea_unit ea_unit_chk chk_i (.*);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  mode_in = '0;
    logic [1:0]  size_in = '0;
    logic [23:0] pc_in = '0;
    logic [3:0]  rf_idx;
    logic [31:0] rf_data;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_data = '0;
    logic        ext_ready, done, an_we, ok_read, ok_write, ok_ctrl;
    logic [31:0] ea, an_wdata;
    logic [3:0]  reg_idx;
    logic [2:0]  an_widx;
    logic [4:0]  cycles;
    logic [31:0] rf [16];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    assign rf_data = rf[rf_idx];

    ea_unit dut_i (.*);

    task automatic chk(input string tag, input string what, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    function automatic string tag_of(input int f);
        if (f < 24) return "R1";
        if (f < 32) return "R2";
        if (f < 40) return "R3";
        if (f < 48) return "R5";
        if (f < 56) return "R6";
        if (f == 58 || f == 59) return "R7";
        if (f > 60) return "R11";
        return "R5";
    endfunction

    task automatic model(input int f, input int sz, input logic [23:0] pcv,
                         input logic [15:0] a, input logic [15:0] b,
                         output logic [31:0] e, output bit we, output logic [31:0] wd,
                         output int cyc, output int ri, output bit lr, output bit lw,
                         output bit lc, output int nw);
        logic [31:0] an, x, off, pcs, s16;
        int step;
        bit big;
        big = (sz == 2);
        an  = rf[8 + (f % 8)];
        x   = rf[a[15:12]];
        off = (a[11] ? x : {{16{x[15]}}, x[15:0]}) + {{24{a[7]}}, a[7:0]};
        pcs = {{8{pcv[23]}}, pcv};
        s16 = {{16{a[15]}}, a};
        step = (sz == 0) ? ((f % 8 == 7) ? 2 : 1) : (sz == 1 ? 2 : 4);
        e = 0; we = 0; wd = 0; cyc = 0; ri = 0; nw = 0;
        lr = (f <= 60);
        lw = (f <= 57);
        lc = (f >= 16 && f < 24) || (f >= 40 && f <= 59);
        if (f < 16) ri = f;
        else if (f < 24) begin e = an; cyc = big ? 8 : 4; end
        else if (f < 32) begin e = an; we = 1; wd = an + step; cyc = big ? 8 : 4; end
        else if (f < 40) begin e = an - step; we = 1; wd = e; cyc = big ? 10 : 6; end
        else if (f < 48) begin e = an + s16; nw = 1; cyc = big ? 12 : 8; end
        else if (f < 56) begin e = an + off; nw = 1; cyc = big ? 14 : 10; end
        else if (f == 56) begin e = s16; nw = 1; cyc = big ? 12 : 8; end
        else if (f == 57) begin e = {a, b}; nw = 2; cyc = big ? 16 : 12; end
        else if (f == 58) begin e = pcs + s16; nw = 1; cyc = big ? 12 : 8; end
        else if (f == 59) begin e = pcs + off; nw = 1; cyc = big ? 14 : 10; end
        else if (f == 60) begin e = big ? {a, b} : {16'd0, a}; nw = big ? 2 : 1; cyc = big ? 8 : 4; end
    endtask

    task automatic run(input int f, input int sz, input logic [23:0] pcv,
                       input logic [15:0] a, input logic [15:0] b, input bit stall);
        logic [31:0] e, wd;
        bit we, lr, lw, lc, acc, stalled;
        int cyc, ri, nw, k, since, guard;
        string t;
        model(f, sz, pcv, a, b, e, we, wd, cyc, ri, lr, lw, lc, nw);
        t = tag_of(f);
        k = 0; since = 0; guard = 0; acc = 0; stalled = 0;
        @(negedge clk);
        start = 1; mode_in = 6'(f); size_in = 2'(sz); pc_in = pcv;
        forever begin
            @(negedge clk);
            start = 0;
            since++;
            if (acc) begin k++; since = 1; end
            if (done) break;
            guard++;
            if (guard > 20) begin
                chk("R10", "done never came", 0, 1);
                ext_valid = 0;
                return;
            end
            chk("R10", "ready only while words owed", ext_ready, (since >= 1 && k < nw) ? 1 : 0);
            ext_valid = (k < nw) && !(stall && !stalled);
            if (stall && k < nw) stalled = 1;
            ext_data = (k == 0) ? a : b;
            acc = ext_valid && ext_ready;
        end
        ext_valid = 0;
        chk("R10", "latency", since, 2);
        chk("R10", "words taken", k, nw);
        chk(t, "ea", ea, e);
        chk(t, "reg_idx", reg_idx, ri);
        chk((f >= 24 && f < 40) ? "R3" : "R2", "an_we", an_we, we);
        if (we) begin
            chk(((f == 31 || f == 39) && sz == 0) ? "R4" : t, "an_wdata", an_wdata, wd);
            chk("R2", "an_widx", an_widx, f % 8);
        end
        chk((f > 60) ? "R11" : "R8", "cycles", cycles, cyc);
        chk("R9", "ok_read", ok_read, lr);
        chk("R9", "ok_write", ok_write, lw);
        chk("R9", "ok_ctrl", ok_ctrl, lc);
        @(negedge clk);
        chk("R10", "done single cycle", done, 0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++)
            rf[i] = 32'h1000_0000 * (i % 3) + 32'h0001_8000 * i + 32'h40 + i;
        rf[15] = 32'h0000_0100;
        rf[3]  = 32'h1234_F00D;
        rf[12] = 32'h0000_7FFE;
        repeat (3) @(negedge clk);
        chk("R10", "reset done", done, 0);
        chk("R10", "reset ext_ready", ext_ready, 0);
        chk("R10", "reset an_we", an_we, 0);
        rst_n = 1;
        for (int iw = 0; iw < 2; iw++)
            for (int f = 0; f < 64; f++)
                for (int sz = 0; sz < 3; sz++) begin
                    logic [15:0] a, b;
                    logic [23:0] pcv;
                    a = {4'((f * 3 + sz + iw * 5) % 16), 1'(iw), 3'b101, 8'(f * 37 + sz * 91 + 128 * iw)};
                    b = 16'(f * 1021 + sz * 77 + 16'h5A5A);
                    pcv = ((f + sz + iw) % 2 == 1) ? 24'hFF_F100 + 24'(f) : 24'h00_2000 + 24'(f * 2);
                    run(f, sz, pcv, a, b, ((f + sz) % 3) == 0);
                end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule